// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck with SDA held low. It works beside the protocol engine. It drives the two lines only through pull-low enables, and it reads the raw line levels back. One start strobe runs a whole recovery. First, a soft-reset request goes to the controller while both overrides stay clear. Then SCL is clocked until the target lets go of SDA. Last, a STOP condition is formed from timed override steps. All timing counts a microsecond tick input, so the block needs no knowledge of the system clock rate.

At the end the block raises `done`. If SDA was still low after the largest allowed number of clocks, it also raises `fail`, so that the controlling logic can ask for a full controller reinitialisation next. Both flags stay valid until the next accepted start.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset the block is idle: `scl_pull`, `sda_pull`, `ctl_rst`, `done` and `fail` are all 0.
- R2: A start strobe in idle begins a preparation step. In that step `ctl_rst` is 1 for STEP_US ticks (5), and both pull enables are 0. `ctl_rst` rises exactly once per recovery.
- R3: Each SCL clock has a pulled-low phase and a released phase. Each phase lasts exactly STEP_US ticks.
- R4: Clocking stops as soon as both lines read high at the end of the preparation step or at the end of a released phase. If the target lets go of SDA after K SCL rising edges (K ≤ 9), exactly K clocks are issued. If the bus is already free, none are issued.
- R5: At most MAX_PULSES (9) clocks are issued. If SDA is still low after the last one, `fail` is 1 when `done` rises. On a successful recovery `fail` is 0.
- R6: The STOP starts with both pull enables rising in the same cycle and held for STEP_US ticks. Next, SCL is released while SDA stays pulled for STEP_US ticks. Last, SDA is released, with SCL already released.
- R7: `done` rises after the STOP with both pull enables 0. `done` and `fail` hold until the next accepted start, which clears them.
- R8: A start strobe while a recovery is in progress is ignored. It causes no second preparation step and no change in the number of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin recovery |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| ctl_rst | output | 1 | Soft-reset request to the protocol engine |
| done | output | 1 | Recovery finished; held until the next start |
| fail | output | 1 | SDA never released; valid while done is 1 |

## Verification
The assertions assume the following about the inputs:
- `us_tick` is a single-cycle pulse that never holds high for long runs.
- The line levels come from an open-drain bus, so a line the block pulls low reads low.

The bench builds both line inputs from the block's own pull enables, combined with a modelled target. That target holds SDA low for a random number of SCL rising edges between 0 and 12. Ticks arrive every fourth clock. Start strobes are driven only between edges, including one injected mid-recovery.

// File: rtl/i2c_bus_unstick.sv
`timescale 1ns/1ps
module i2c_bus_unstick #(
  parameter int STEP_US    = 5,
  parameter int MAX_PULSES = 9,
  localparam int TW = $clog2(STEP_US + 1),
  localparam int PW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic us_tick,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic ctl_rst,
  output logic done,
  output logic fail
);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_LOW, S_HIGH, S_STOP1, S_STOP2} st_t;

  st_t           state;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pulses;
  logic          stuck;

  wire step_end = us_tick && (tcnt == TW'(STEP_US - 1));
  wire bus_free = scl_in && sda_in;

  assign scl_pull = (state == S_LOW) || (state == S_STOP1);
  assign sda_pull = (state == S_STOP1) || (state == S_STOP2);
  assign ctl_rst  = (state == S_PREP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      tcnt   <= '0;
      pulses <= '0;
      stuck  <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      if (state == S_IDLE)  tcnt <= '0;
      else if (us_tick)     tcnt <= step_end ? '0 : tcnt + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          state  <= S_PREP;
          done   <= 1'b0;
          fail   <= 1'b0;
          pulses <= '0;
          stuck  <= 1'b0;
        end
        S_PREP: if (step_end) state <= bus_free ? S_STOP1 : S_LOW;
        S_LOW:  if (step_end) state <= S_HIGH;
        S_HIGH: if (step_end) begin
          pulses <= pulses + 1'b1;
          if (bus_free) state <= S_STOP1;
          else if (pulses == PW'(MAX_PULSES - 1)) begin
            stuck <= 1'b1;
            state <= S_STOP1;
          end else state <= S_LOW;
        end
        S_STOP1: if (step_end) state <= S_STOP2;
        S_STOP2: if (step_end) begin
          state <= S_IDLE;
          done  <= 1'b1;
          fail  <= stuck;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_prep_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |-> !scl_pull && !sda_pull);
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !us_tick) |=> $stable(state));
  a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PW'(MAX_PULSES));
  a_r6_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> scl_pull);
  a_r6_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);
  a_r7_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scl_pull && !sda_pull && !ctl_rst);
  a_r7_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOW && start) |=> (state == S_LOW || state == S_HIGH));

endmodule

// File: tb/test_i2c_bus_unstick.sv
`timescale 1ns/1ps
module test_i2c_bus_unstick;
  localparam int STEP = 5;
  localparam int MAXP = 9;
  localparam int TDIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, us_tick = 1'b0;
  logic scl_pull, sda_pull, ctl_rst, done, fail;
  logic scl_in, sda_in;
  logic hold = 1'b0;
  int   k_edges = 0, rises = 0, tc = 0;
  int   tests = 0, fails = 0;

  int mon_pulses, lo_min, lo_max, low_len, both_len, sda_len, rst_len, rst_rises;
  bit entry_ok, edge_ok, prep_ok;
  logic p_scl = 1'b0, p_sda = 1'b0, p_rst = 1'b0, p_line = 1'b1;

  always #2 clk = ~clk;

  assign scl_in = !scl_pull;
  assign sda_in = !sda_pull && !hold;

  i2c_bus_unstick #(.STEP_US(STEP), .MAX_PULSES(MAXP)) i_i2c_bus_unstick (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .ctl_rst(ctl_rst), .done(done), .fail(fail));

  function automatic int exp_pulses(int k);
    return (k > MAXP) ? MAXP : k;
  endfunction
  function automatic bit exp_fail(int k);
    return k > MAXP;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tc <= (tc == TDIV - 1) ? 0 : tc + 1;
    us_tick <= (tc == TDIV - 2);
    if (scl_in && !p_line) begin
      rises <= rises + 1;
      if (rises + 1 >= k_edges) hold <= 1'b0;
    end
    p_line <= scl_in;
    if (scl_pull && !p_scl && !sda_pull) mon_pulses <= mon_pulses + 1;
    if (scl_pull && !sda_pull) low_len <= low_len + 1;
    if (!scl_pull && p_scl && !p_sda) begin
      if (low_len < lo_min) lo_min <= low_len;
      if (low_len > lo_max) lo_max <= low_len;
      low_len <= 0;
    end
    if (scl_pull && sda_pull) both_len <= both_len + 1;
    if (sda_pull && !scl_pull) sda_len <= sda_len + 1;
    if (sda_pull && !p_sda && !scl_pull) entry_ok <= 1'b0;
    if (!sda_pull && p_sda && scl_pull) edge_ok <= 1'b0;
    if (ctl_rst) begin
      rst_len <= rst_len + 1;
      if (scl_pull || sda_pull) prep_ok <= 1'b0;
    end
    if (ctl_rst && !p_rst) rst_rises <= rst_rises + 1;
    p_scl <= scl_pull; p_sda <= sda_pull; p_rst <= ctl_rst;
  end

  task automatic run(int k, bit busy_start);
    int n;
    @(posedge clk); #1;
    k_edges = k; hold = (k != 0); rises = 0;
    mon_pulses = 0; lo_min = 1000; lo_max = 0; low_len = 0;
    both_len = 0; sda_len = 0; rst_len = 0; rst_rises = 0;
    entry_ok = 1; edge_ok = 1; prep_ok = 1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(done == 0 && fail == 0, "R7 start clears flags", {30'd0, done, fail}, 0);
    n = 0;
    while (!done && n < 4000) begin
      @(posedge clk); #1;
      n++;
      if (busy_start && n == 60) start = 1'b1;
      if (busy_start && n == 61) start = 1'b0;
    end
    if (!done) begin
      chk(0, "R7 done never rose", 0, 1);
      return;
    end
    @(negedge clk);
    chk(mon_pulses == exp_pulses(k), busy_start ? "R8 R4 clock count" : "R4 clock count",
        mon_pulses, exp_pulses(k));
    chk(fail == exp_fail(k), "R5 fail flag", fail, exp_fail(k));
    chk(rst_rises == 1, "R2 one reset request", rst_rises, 1);
    chk(rst_len > (STEP - 1) * TDIV && rst_len <= STEP * TDIV && prep_ok,
        "R2 reset step", rst_len, STEP * TDIV);
    if (k > 0)
      chk(lo_min == STEP * TDIV && lo_max == STEP * TDIV, "R3 low phase", lo_max, STEP * TDIV);
    chk(both_len == STEP * TDIV && entry_ok, "R6 both pulled", both_len, STEP * TDIV);
    chk(sda_len == STEP * TDIV && edge_ok, "R6 sda only", sda_len, STEP * TDIV);
    repeat (30) @(posedge clk);
    #1;
    chk(done == 1 && fail == exp_fail(k) && !scl_pull && !sda_pull,
        "R7 flags held", {30'd0, done, fail}, {30'd0, 1'b1, exp_fail(k)});
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk({scl_pull, sda_pull, ctl_rst, done, fail} == 5'b0, "R1 reset state",
        {scl_pull, sda_pull, ctl_rst, done, fail}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk({scl_pull, sda_pull, ctl_rst, done, fail} == 5'b0, "R1 idle after reset",
        {scl_pull, sda_pull, ctl_rst, done, fail}, 0);
    run(0, 0);
    run(1, 0);
    run(9, 0);
    run(10, 0);
    run(12, 0);
    run(6, 1);
    for (int i = 0; i < 12; i++) run(int'($urandom % 13), i[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule